// File: doc/BRIEF.md
# I2C byte FIFO pair with level-driven threshold flags

This block holds the data bytes of an I2C controller in two independent first-in first-out queues. Software reaches both through one data location: a register write stores a byte for transmission and a register read takes the oldest received byte. The serial bit engine works on the other side. It takes bytes out of the transmit queue and puts received bytes into the receive queue.

Each queue reports how many bytes it holds and whether it is empty or full. It also raises a threshold flag that follows the fill level: the receive flag is high while enough bytes are waiting, and the transmit flag is high while the transmit queue has run low. Software can empty either queue with a one-shot flush request. The transmit queue also empties itself on selected bus events: an own-address match, a general call match, or a NACK that ends a slave transfer. Each of these events can be disabled on its own.

Two sticky fault flags report a slave receive overflow and a slave transmit underflow. A receive byte counter is loaded with the length of a transfer and counts it down. A programmed length of 0 stands for 256 bytes.

Top module: `i2cq_fifo_pair`

## Requirements
- R1: Bytes leave each queue in the order they entered. A `reg_wr` stores `reg_wdata` in the transmit queue, and `eng_tx_data` always shows the oldest transmit byte. An `eng_rx_push` stores `eng_rx_data` in the receive queue. A `reg_rd` places the oldest receive byte on `reg_rdata` one clock later and removes it from the queue.
- R2: `rx_count` and `tx_count` give the number of stored bytes, never more than DEPTH. The empty outputs are 1 exactly when the count is 0, and the full outputs are 1 exactly when the count equals DEPTH.
- R3: `rx_thr_flag` is 1 exactly while `rx_count` >= `rx_thresh`. It drops by itself once the count falls below the threshold.
- R4: `tx_thr_flag` is 1 exactly while `tx_count` <= `tx_thresh`. It drops by itself once the count rises above the threshold.
- R5: A register write while the transmit queue is full is ignored, and so is an engine push while the receive queue is full. The count and the stored bytes are unchanged.
- R6: A register read while the receive queue is empty returns 0 on `reg_rdata` and changes no count.
- R7: A one-cycle flush request sets the matching busy bit at the next clock. At the clock after that, the queue is emptied and the busy bit returns to 0 by itself.
- R8: While `ctl_en` is 0, the receive queue is emptied at every clock and engine pushes are ignored.
- R9: An event on `ev_addr_match`, `ev_gcall_match` or `ev_slv_nack` empties the transmit queue at that clock, unless that event's own disable input (`af_dis_addr`, `af_dis_gcall`, `af_dis_nack`) is 1.
- R10: `rx_ovf_flag` sets when `ev_first_bit` arrives while `slv_rx_active` is 1, the receive queue is full and `shreg_full` is 1. It stays set until an `ovf_clr` pulse, and a set in the same cycle takes priority over the clear.
- R11: `tx_unf_flag` sets when `ev_first_bit` arrives while `slv_tx_active` is 1, the transmit queue is empty and `master_nacked` is 0. It stays set until an `unf_clr` pulse, and a set in the same cycle takes priority over the clear.
- R12: `xfer_load` loads `xfer_left` with `xfer_target`, except that a target of 0 loads 256. Each accepted receive byte lowers `xfer_left` by one, down to 0, and `xfer_done` is 1 while `xfer_left` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_en | input | 1 | Controller enable; 0 holds the receive queue empty |
| reg_wr | input | 1 | Register write to the data location |
| reg_wdata | input | DW | Byte written by software |
| reg_rd | input | 1 | Register read of the data location |
| reg_rdata | output | DW | Byte returned by the last read |
| rx_thresh | input | TW | Receive threshold level |
| tx_thresh | input | TW | Transmit threshold level |
| rx_flush_req | input | 1 | Software writes 1 to flush the receive queue |
| tx_flush_req | input | 1 | Software writes 1 to flush the transmit queue |
| rx_flush_busy | output | 1 | Receive flush bit, clears by itself |
| tx_flush_busy | output | 1 | Transmit flush bit, clears by itself |
| af_dis_addr | input | 1 | Disable auto flush on address match |
| af_dis_gcall | input | 1 | Disable auto flush on general call match |
| af_dis_nack | input | 1 | Disable auto flush on end-of-transfer NACK |
| ev_addr_match | input | 1 | Slave address match event |
| ev_gcall_match | input | 1 | General call match event |
| ev_slv_nack | input | 1 | NACK ending a slave transfer |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | DW | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | DW | Received byte |
| rx_count | output | CW | Receive queue level |
| tx_count | output | CW | Transmit queue level |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_thr_flag | output | 1 | Receive level at or above threshold |
| tx_thr_flag | output | 1 | Transmit level at or below threshold |
| ev_first_bit | input | 1 | First data bit of a byte reached |
| slv_rx_active | input | 1 | Acting as slave receiver |
| slv_tx_active | input | 1 | Acting as slave transmitter |
| shreg_full | input | 1 | Engine receive shift register holds a byte |
| master_nacked | input | 1 | Master has already answered NACK |
| ovf_clr | input | 1 | Clear the overflow flag |
| unf_clr | input | 1 | Clear the underflow flag |
| rx_ovf_flag | output | 1 | Sticky receive overflow |
| tx_unf_flag | output | 1 | Sticky transmit underflow |
| xfer_load | input | 1 | Load the receive byte target |
| xfer_target | input | LW | Target byte count, 0 means 256 |
| xfer_left | output | LW+1 | Bytes still expected |
| xfer_done | output | 1 | No bytes left |

## Verification
The bench builds the block with DEPTH = 6, so the count ports are three bits wide. This makes the queues fill after a few writes, and the read and write pointers wrap at a depth that is not a power of two. With a 4-bit threshold above the depth, a setting of 7 shows the transmit flag stuck high and the receive flag never reached. The receive target keeps its default 8-bit width, so the 0-means-256 load is seen as the ninth bit of `xfer_left`.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    typedef struct packed {
        logic addr;
        logic gcall;
        logic nack;
    } i2cq_evt_t;

    function automatic logic i2cq_autoflush_hit(input i2cq_evt_t ev, input i2cq_evt_t dis);
        return (ev.addr & ~dis.addr) | (ev.gcall & ~dis.gcall) | (ev.nack & ~dis.nack);
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == FULL_CNT);
    assign count   = st_q.cnt;
    assign head    = st_q.mem[st_q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = wdata;
                st_d.wr           = nxt_ptr(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = nxt_ptr(st_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R5
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/i2cq_fault_det.sv
module i2cq_fault_det (
    input  logic clk,
    input  logic rst_n,
    input  logic first_bit,
    input  logic slv_rx,
    input  logic slv_tx,
    input  logic rx_full,
    input  logic shreg_full,
    input  logic tx_empty,
    input  logic master_nacked,
    input  logic ovf_clr,
    input  logic unf_clr,
    output logic rx_ovf,
    output logic tx_unf
);
    typedef struct packed {
        logic ovf;
        logic unf;
    } fault_st_t;

    fault_st_t st_d, st_q;
    logic      ovf_hit, unf_hit;

    assign ovf_hit = first_bit && slv_rx && rx_full && shreg_full;
    assign unf_hit = first_bit && slv_tx && tx_empty && !master_nacked;

    always_comb begin
        st_d = st_q;
        if (ovf_clr) st_d.ovf = 1'b0;
        if (ovf_hit) st_d.ovf = 1'b1;
        if (unf_clr) st_d.unf = 1'b0;
        if (unf_hit) st_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_ovf = st_q.ovf;
    assign tx_unf = st_q.unf;

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_bit && slv_rx && rx_full && shreg_full) |=> rx_ovf);

    // R11
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_bit && slv_tx && tx_empty && !master_nacked) |=> tx_unf);

    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !ovf_clr) |=> rx_ovf);

endmodule

// File: rtl/i2cq_xfer_cnt.sv
module i2cq_xfer_cnt #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] target,
    input  logic          dec,
    output logic [LW:0]   remaining,
    output logic          done
);
    localparam logic [LW:0] MAX_LEN = {1'b1, {LW{1'b0}}};

    typedef struct packed {
        logic [LW:0] left;
    } xfer_st_t;

    xfer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.left = (target == '0) ? MAX_LEN : {1'b0, target};
        end else if (dec && st_q.left != '0) begin
            st_d.left = st_q.left - (LW + 1)'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign remaining = st_q.left;
    assign done      = (st_q.left == '0);

    // R12
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && target == '0) |=> remaining == MAX_LEN);

    // R12
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && remaining != '0) |=> remaining == $past(remaining) - (LW + 1)'(1));

endmodule

// File: rtl/i2cq_fifo_pair.sv
module i2cq_fifo_pair
    import i2cq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int TW    = 4,
    parameter int LW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_rd,
    output logic [DW-1:0] reg_rdata,
    input  logic [TW-1:0] rx_thresh,
    input  logic [TW-1:0] tx_thresh,
    input  logic          rx_flush_req,
    input  logic          tx_flush_req,
    output logic          rx_flush_busy,
    output logic          tx_flush_busy,
    input  logic          af_dis_addr,
    input  logic          af_dis_gcall,
    input  logic          af_dis_nack,
    input  logic          ev_addr_match,
    input  logic          ev_gcall_match,
    input  logic          ev_slv_nack,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_count,
    output logic          rx_empty,
    output logic          rx_full,
    output logic          tx_empty,
    output logic          tx_full,
    output logic          rx_thr_flag,
    output logic          tx_thr_flag,
    input  logic          ev_first_bit,
    input  logic          slv_rx_active,
    input  logic          slv_tx_active,
    input  logic          shreg_full,
    input  logic          master_nacked,
    input  logic          ovf_clr,
    input  logic          unf_clr,
    output logic          rx_ovf_flag,
    output logic          tx_unf_flag,
    input  logic          xfer_load,
    input  logic [LW-1:0] xfer_target,
    output logic [LW:0]   xfer_left,
    output logic          xfer_done
);
    localparam int MW = (CW > TW) ? CW : TW;

    typedef struct packed {
        logic          rx_fl;
        logic          tx_fl;
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t   st_d, st_q;
    i2cq_evt_t ev_vec, dis_vec;
    logic      auto_tx_flush, rx_flush, tx_flush, rx_push, rx_accept;
    logic [DW-1:0] rx_head;

    assign ev_vec        = '{addr: ev_addr_match, gcall: ev_gcall_match, nack: ev_slv_nack};
    assign dis_vec       = '{addr: af_dis_addr, gcall: af_dis_gcall, nack: af_dis_nack};
    assign auto_tx_flush = i2cq_autoflush_hit(ev_vec, dis_vec);

    assign rx_flush  = st_q.rx_fl || !ctl_en;
    assign tx_flush  = st_q.tx_fl || auto_tx_flush;
    assign rx_push   = eng_rx_push && ctl_en;
    assign rx_accept = rx_push && !rx_full && !rx_flush;

    i2cq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .wdata (eng_rx_data),
        .pop   (reg_rd),
        .head  (rx_head),
        .count (rx_count),
        .empty (rx_empty),
        .full  (rx_full)
    );

    i2cq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (reg_wr),
        .wdata (reg_wdata),
        .pop   (eng_tx_pop),
        .head  (eng_tx_data),
        .count (tx_count),
        .empty (tx_empty),
        .full  (tx_full)
    );

    i2cq_fault_det u_fault (
        .clk           (clk),
        .rst_n         (rst_n),
        .first_bit     (ev_first_bit),
        .slv_rx        (slv_rx_active),
        .slv_tx        (slv_tx_active),
        .rx_full       (rx_full),
        .shreg_full    (shreg_full),
        .tx_empty      (tx_empty),
        .master_nacked (master_nacked),
        .ovf_clr       (ovf_clr),
        .unf_clr       (unf_clr),
        .rx_ovf        (rx_ovf_flag),
        .tx_unf        (tx_unf_flag)
    );

    i2cq_xfer_cnt #(.LW(LW)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (xfer_load),
        .target    (xfer_target),
        .dec       (rx_accept),
        .remaining (xfer_left),
        .done      (xfer_done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rx_fl = rx_flush_req;
        st_d.tx_fl = tx_flush_req;
        if (reg_rd) begin
            st_d.rdata = rx_empty ? '0 : rx_head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata     = st_q.rdata;
    assign rx_flush_busy = st_q.rx_fl;
    assign tx_flush_busy = st_q.tx_fl;
    assign rx_thr_flag   = MW'(rx_count) >= MW'(rx_thresh);
    assign tx_thr_flag   = MW'(tx_count) <= MW'(tx_thresh);

    // R7
    flush_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush_busy && !rx_flush_req) |=> !rx_flush_busy);

    // R8
    rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> rx_empty);

    // R9
    autoflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_addr_match && !af_dis_addr) || (ev_gcall_match && !af_dis_gcall)
         || (ev_slv_nack && !af_dis_nack)) |=> tx_empty);

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && rx_empty) |=> reg_rdata == '0);

endmodule

// File: tb/sim_i2cq_fifo_pair.sv
module sim_i2cq_fifo_pair;
    localparam int DW    = 8;
    localparam int DEPTH = 6;
    localparam int TW    = 4;
    localparam int LW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0, ctl_en = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata, eng_tx_data, eng_rx_data = '0;
    logic [TW-1:0] rx_thresh = 4'd3, tx_thresh = 4'd2;
    logic rx_flush_req = 0, tx_flush_req = 0, rx_flush_busy, tx_flush_busy;
    logic af_dis_addr = 0, af_dis_gcall = 0, af_dis_nack = 0;
    logic ev_addr_match = 0, ev_gcall_match = 0, ev_slv_nack = 0;
    logic eng_tx_pop = 0, eng_rx_push = 0;
    logic [CW-1:0] rx_count, tx_count;
    logic rx_empty, rx_full, tx_empty, tx_full, rx_thr_flag, tx_thr_flag;
    logic ev_first_bit = 0, slv_rx_active = 0, slv_tx_active = 0, shreg_full = 0;
    logic master_nacked = 0, ovf_clr = 0, unf_clr = 0, rx_ovf_flag, tx_unf_flag;
    logic xfer_load = 0, xfer_done;
    logic [LW-1:0] xfer_target = '0;
    logic [LW:0] xfer_left;

    int checks = 0, errors = 0;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];

    always #4 clk = ~clk;

    i2cq_fifo_pair #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .LW(LW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_levels(input string req);
        check({req, " tx_count"}, 32'(tx_count), txq.size());
        check({req, " rx_count"}, 32'(rx_count), rxq.size());
        check({req, " tx_full"}, 32'(tx_full), 32'(txq.size() == DEPTH));
        check({req, " rx_empty"}, 32'(rx_empty), 32'(rxq.size() == 0));
    endtask

    // driver: software write, expected byte goes into scoreboard
    task automatic sw_write(input logic [DW-1:0] b);
        reg_wr = 1; reg_wdata = b;
        if (txq.size() < DEPTH) txq.push_back(b);
        step();
        reg_wr = 0;
    endtask

    // monitor: engine takes a byte, compared against the scoreboard head
    task automatic eng_pop(input string req);
        if (txq.size() > 0) check({req, " eng_tx_data"}, 32'(eng_tx_data), 32'(txq.pop_front()));
        eng_tx_pop = 1;
        step();
        eng_tx_pop = 0;
    endtask

    task automatic eng_push(input logic [DW-1:0] b);
        eng_rx_push = 1; eng_rx_data = b;
        if (ctl_en && rxq.size() < DEPTH) rxq.push_back(b);
        step();
        eng_rx_push = 0;
    endtask

    task automatic sw_read(input string req);
        logic [DW-1:0] exp;
        exp = (rxq.size() > 0) ? rxq.pop_front() : '0;
        reg_rd = 1;
        step();
        reg_rd = 0;
        check({req, " reg_rdata"}, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic sw_tx_flush();
        tx_flush_req = 1; step(); tx_flush_req = 0; step();
        txq.delete();
    endtask

    task automatic sw_rx_flush();
        rx_flush_req = 1; step(); rx_flush_req = 0; step();
        rxq.delete();
    endtask

    bit finished = 0;

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // reset state
        chk_levels("R2 reset");
        check("R4 reset tx_thr_flag", 32'(tx_thr_flag), 1);
        check("R3 reset rx_thr_flag", 32'(rx_thr_flag), 0);
        check("R10 reset rx_ovf_flag", 32'(rx_ovf_flag), 0);
        check("R12 reset xfer_done", 32'(xfer_done), 1);

        // R1 / R4: write three, watch tx flag drop and return
        sw_write(8'hA1); sw_write(8'hB2); sw_write(8'hC3);
        chk_levels("R1 after writes");
        check("R4 flag above thresh", 32'(tx_thr_flag), 0);
        eng_pop("R1");
        check("R4 flag at thresh", 32'(tx_thr_flag), 1);
        eng_pop("R1"); eng_pop("R1");
        chk_levels("R2 drained");

        // R5 / R2: fill past full with wrap-around
        for (int i = 0; i < DEPTH + 2; i++) sw_write(8'(8'h10 + i));
        chk_levels("R5 tx full");
        check("R5 tx_full", 32'(tx_full), 1);
        for (int i = 0; i < DEPTH; i++) eng_pop("R5 order after ignored write");
        check("R2 tx_empty", 32'(tx_empty), 1);

        // R4: threshold above depth keeps flag high
        tx_thresh = 4'd7;
        for (int i = 0; i < DEPTH; i++) sw_write(8'(8'h40 + i));
        check("R4 thresh over depth", 32'(tx_thr_flag), 1);
        sw_tx_flush();
        tx_thresh = 4'd2;

        // R3 / R1 receive path
        ctl_en = 1;
        step();
        eng_push(8'h55); eng_push(8'h66);
        check("R3 below thresh", 32'(rx_thr_flag), 0);
        eng_push(8'h77);
        check("R3 at thresh", 32'(rx_thr_flag), 1);
        sw_read("R1 rx head");
        check("R3 drops below", 32'(rx_thr_flag), 0);
        sw_read("R1"); sw_read("R1");
        // R6 empty read
        sw_read("R6 empty read");
        chk_levels("R6 levels unchanged");

        // R5 receive full
        for (int i = 0; i < DEPTH + 1; i++) eng_push(8'(8'h80 + i));
        chk_levels("R5 rx full");
        rx_thresh = 4'd7;
        step();
        check("R3 thresh over depth", 32'(rx_thr_flag), 0);
        rx_thresh = 4'd3;

        // R10 overflow
        slv_rx_active = 1; ev_first_bit = 1; shreg_full = 0;
        step(); ev_first_bit = 0;
        check("R10 no ovf without shreg_full", 32'(rx_ovf_flag), 0);
        shreg_full = 1; ev_first_bit = 1;
        step(); ev_first_bit = 0;
        check("R10 ovf set", 32'(rx_ovf_flag), 1);
        step();
        check("R10 ovf sticky", 32'(rx_ovf_flag), 1);
        ovf_clr = 1; step(); ovf_clr = 0;
        check("R10 ovf cleared", 32'(rx_ovf_flag), 0);
        slv_rx_active = 0; shreg_full = 0;

        // R7 receive flush timing
        rx_flush_req = 1; step(); rx_flush_req = 0;
        check("R7 busy set", 32'(rx_flush_busy), 1);
        check("R7 count kept", 32'(rx_count), DEPTH);
        step();
        rxq.delete();
        check("R7 busy self clear", 32'(rx_flush_busy), 0);
        chk_levels("R7 rx flushed");

        // R7 transmit flush
        sw_write(8'h01); sw_write(8'h02);
        tx_flush_req = 1; step(); tx_flush_req = 0;
        check("R7 tx busy", 32'(tx_flush_busy), 1);
        step();
        txq.delete();
        check("R7 tx busy clear", 32'(tx_flush_busy), 0);
        chk_levels("R7 tx flushed");

        // R8 disable
        eng_push(8'h99); eng_push(8'h9A);
        ctl_en = 0; step();
        rxq.delete();
        chk_levels("R8 disabled flush");
        eng_push(8'h9B);
        chk_levels("R8 push ignored");
        ctl_en = 1; step();

        // R9 auto flush per event and disable
        for (int k = 0; k < 3; k++) begin
            for (int d = 0; d < 2; d++) begin
                sw_write(8'h20); sw_write(8'h21);
                af_dis_addr = (k == 0) && d; af_dis_gcall = (k == 1) && d; af_dis_nack = (k == 2) && d;
                ev_addr_match = (k == 0); ev_gcall_match = (k == 1); ev_slv_nack = (k == 2);
                step();
                ev_addr_match = 0; ev_gcall_match = 0; ev_slv_nack = 0;
                if (!d) txq.delete();
                check("R9 auto flush", 32'(tx_count), txq.size());
                af_dis_addr = 0; af_dis_gcall = 0; af_dis_nack = 0;
                sw_tx_flush();
            end
        end

        // R11 underflow
        slv_tx_active = 1; master_nacked = 1; ev_first_bit = 1;
        step(); ev_first_bit = 0;
        check("R11 no unf after nack", 32'(tx_unf_flag), 0);
        master_nacked = 0; ev_first_bit = 1; unf_clr = 1;
        step(); ev_first_bit = 0; unf_clr = 0;
        check("R11 unf set beats clear", 32'(tx_unf_flag), 1);
        unf_clr = 1; step(); unf_clr = 0;
        check("R11 unf cleared", 32'(tx_unf_flag), 0);
        sw_write(8'h33);
        ev_first_bit = 1; step(); ev_first_bit = 0;
        check("R11 no unf with data", 32'(tx_unf_flag), 0);
        slv_tx_active = 0;
        sw_tx_flush();

        // R12 transfer length
        xfer_load = 1; xfer_target = 8'd0; step(); xfer_load = 0;
        check("R12 zero means 256", 32'(xfer_left), 256);
        check("R12 not done", 32'(xfer_done), 0);
        xfer_load = 1; xfer_target = 8'd3; step(); xfer_load = 0;
        eng_push(8'h01); eng_push(8'h02);
        check("R12 left one", 32'(xfer_left), 1);
        eng_push(8'h03);
        check("R12 done", 32'(xfer_done), 1);
        eng_push(8'h04);
        check("R12 stays zero", 32'(xfer_left), 0);
        sw_rx_flush();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule